// File: doc/BRIEF.md
# Discrete-Input Serial Readout Slave

This block samples a bank of discrete input levels and hands them to a host as a serial bit stream, acting as a slave on an SPI bus in mode 0 (clock idles low, data captured on the rising edge). Each input line is of the ground/open kind with a pull-up outside the block. An open line arrives as logic 1 and a grounded line arrives as logic 0. Level sensing, filtering and surge protection sit outside the block; only digital levels reach it.

The host selects the block by pulling the active-low select line down. That falling edge takes a snapshot of all inputs into a shift register. Each later rising serial clock edge moves the register one place toward the output stage and pulls a new bit in from the serial input. Because of this, several blocks can be chained by wiring one block's output to the next block's serial input. The output is driven only while the block is selected. The tri-state buffer sits outside the block and is controlled by a separate enable output. All serial inputs are oversampled and edge-detected in the system clock domain, so the block is fully synchronous.

Top module: `discrete_spi_slave`

## Requirements
- R1: After reset the shift register holds all zeros, `dataOut` is 0 and `outEn` is 0.
- R2: On a falling edge of `csN`, every register stage loads at once from its input. Stage N takes `din[N-1]`, with stage 1 at bit 0 and stage 8 at bit 7. A 1 on `din` means an open line and a 0 means a grounded line.
- R3: `dataOut` always shows the highest stage. After a load the first bit presented is `din[7]`.
- R4: While `csN` is low, each rising `sclk` edge moves every stage up by one place. The bits therefore appear in the order `din[7]`, `din[6]`, ... `din[0]`.
- R5: On each shift, the value on `sdi` at the rising `sclk` edge enters stage 1. After eight more edges, the `sdi` bits come out in the order they went in.
- R6: While `csN` is high, `outEn` is 0 and `sclk` edges leave the register, and so `dataOut`, unchanged.
- R7: If `sdi` is held at 0, which is the pull-down value of an unconnected input, eight shifts after the last data bit leave the register all zeros.
- R8: Shifting continues past the eighth edge. A change on `din` during a selected frame has no effect until the next falling edge of `csN`.
- R9: With two blocks chained (the first block's `dataOut` feeding the second block's `sdi`, and shared `csN` and `sclk`), sixteen edges return the second block's eight bits followed by the first block's eight bits, highest bit first.
- R10: `outEn` is 1 exactly while the synchronized `csN` is low. It rises in the same cycle as the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Active-low select. Its falling edge loads, its low level enables shifting, its high level releases the output |
| sclk | input | 1 | Serial clock. The rising edge shifts |
| sdi | input | 1 | Serial daisy-chain input into stage 1 |
| din | input | CHANNELS | Discrete input levels, where 1 means open and 0 means grounded |
| dataOut | output | 1 | Content of the highest register stage |
| outEn | output | 1 | Enable for the external tri-state buffer on `dataOut` |

## Verification
The checker verifies these points on every cycle:
- a load strobe captures exactly the input word;
- a shift strobe moves every stage by one place and takes in the synchronized serial bit;
- the register holds when neither strobe is active;
- the output enable never rises without a load;
- the output stays frozen while the block is deselected.

Only the bench scenarios can show the end-to-end behaviour, which involves the edge detection against real pin waveforms. These scenarios cover:
- the bit order seen by a host for every one of the 256 input words;
- the zero fill from a quiet serial input;
- the fact that a change on the inputs in mid-frame is ignored;
- the sixteen-bit order of a two-block chain.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic load;   // snapshot the parallel inputs
    logic shift;  // move every stage up by one place
  } dsrStrobes_t;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stageQ[i] <= RESET_VAL;
        else       stageQ[i] <= dIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stageQ[i] <= RESET_VAL;
        else       stageQ[i] <= stageQ[i-1];
    end
  end

  assign dOut = stageQ[STAGES-1];
endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  output dsrStrobes_t ctl,
  output logic        sdiBit,
  output logic        selected
);
  localparam int IDX_SDI  = 0;
  localparam int IDX_SCLK = 1;
  localparam int IDX_CS   = 2;
  localparam int NUM_LINES = 3;
  localparam logic [NUM_LINES-1:0] LINE_IDLE = 3'b100;

  logic [NUM_LINES-1:0] rawLines, syncLines;
  logic prevCs, prevSclk;
  logic csS, sclkS, csFall, sclkRise;

  assign rawLines = {csN, sclk, sdi};

  // All three lines pass through the same depth, so sdi stays aligned to the sclk edge
  dsr_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RESET_VAL(LINE_IDLE)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (rawLines),
    .dOut (syncLines)
  );

  assign csS    = syncLines[IDX_CS];
  assign sclkS  = syncLines[IDX_SCLK];
  assign sdiBit = syncLines[IDX_SDI];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs   <= 1'b1;
      prevSclk <= 1'b0;
    end else begin
      prevCs   <= csS;
      prevSclk <= sclkS;
    end
  end

  assign csFall   = prevCs & ~csS;
  assign sclkRise = ~prevSclk & sclkS;
  assign selected = ~csS;

  // A load takes priority over a shift in the same cycle
  always_comb begin
    ctl.load  = csFall;
    ctl.shift = sclkRise & selected & ~csFall;
  end
endmodule

// File: rtl/dsr_datapath.sv
module dsr_datapath
  import dsr_pkg::*;
#(
  parameter int CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dsrStrobes_t         ctl,
  input  logic [CHANNELS-1:0] din,
  input  logic                sdiBit,
  output logic [CHANNELS-1:0] stages,
  output logic                dataOut
);
  localparam int TOP = CHANNELS - 1;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_cell
    logic shiftSrc;
    if (i == 0) begin : g_entry
      assign shiftSrc = sdiBit;
    end else begin : g_link
      assign shiftSrc = stages[i-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          stages[i] <= 1'b0;
      else if (ctl.load)  stages[i] <= din[i];
      else if (ctl.shift) stages[i] <= shiftSrc;
    end
  end

  assign dataOut = stages[TOP];
endmodule

// File: rtl/discrete_spi_slave.sv
module discrete_spi_slave
  import dsr_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                sdi,
  input  logic [CHANNELS-1:0] din,
  output logic                dataOut,
  output logic                outEn
);
  dsrStrobes_t         ctl;
  logic                sdiBit;
  logic                selected;
  logic [CHANNELS-1:0] stages;

  dsr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sclk     (sclk),
    .sdi      (sdi),
    .ctl      (ctl),
    .sdiBit   (sdiBit),
    .selected (selected)
  );

  dsr_datapath #(.CHANNELS(CHANNELS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .din     (din),
    .sdiBit  (sdiBit),
    .stages  (stages),
    .dataOut (dataOut)
  );

  assign outEn = selected;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker
  import dsr_pkg::*;
#(
  parameter int CHANNELS = 8
) (
  input logic                clk,
  input logic                rstN,
  input dsrStrobes_t         ctl,
  input logic [CHANNELS-1:0] stages,
  input logic [CHANNELS-1:0] din,
  input logic                sdiBit,
  input logic                dataOut,
  input logic                outEn
);
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> stages == $past(din)); // R2

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |=> stages == {$past(stages[CHANNELS-2:0]), $past(sdiBit)}); // R4 R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.shift) |=> $stable(stages)); // R8

  AST_ENABLE_WITH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEn) |-> ctl.load); // R10

  AST_DESELECT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |=> $stable(dataOut)); // R6
endmodule

bind discrete_spi_slave dsr_checker #(.CHANNELS(CHANNELS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ctl     (ctl),
  .stages  (stages),
  .din     (din),
  .sdiBit  (sdiBit),
  .dataOut (dataOut),
  .outEn   (outEn)
);

// File: tb/sim_discrete_spi_slave.sv
module sim_discrete_spi_slave;
  localparam int CH = 8;
  localparam int HALF = 6;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, csN, sclk, sdi;
  logic [CH-1:0] dinA, dinB;
  logic outA, enA, outB, enB;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  discrete_spi_slave #(.CHANNELS(CH)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .din(dinA), .dataOut(outA), .outEn(enA));

  discrete_spi_slave #(.CHANNELS(CH)) u1 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(outA),
    .din(dinB), .dataOut(outB), .outEn(enB));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; waitClk(HALF);
    sclk = 1'b0; waitClk(HALF);
  endtask

  task automatic selectDev();
    csN = 1'b0; waitClk(HALF);
  endtask

  task automatic deselectDev();
    csN = 1'b1; waitClk(HALF);
  endtask

  // Sample, then clock, n times; feed is sent highest bit first
  task automatic readBits(input int n, input logic [31:0] feed, input bit fromSecond,
                          output logic [31:0] word);
    word = '0;
    for (int i = 0; i < n; i++) begin
      sdi = feed[n-1-i];
      waitClk(2);
      word = {word[30:0], fromSecond ? outB : outA};
      pulse();
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles == LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, w2;
    logic [7:0] pat [4];
    logic [7:0] chA [4];
    logic [7:0] chB [4];
    logic held;
    pat = '{8'hA5, 8'h3C, 8'h01, 8'h80};
    chA = '{8'h12, 8'hFF, 8'h00, 8'h96};
    chB = '{8'hED, 8'h00, 8'hFF, 8'h69};

    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0; dinA = '0; dinB = '0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    check(outA == 1'b0, "R1 dataOut", outA, 0);
    check(enA == 1'b0, "R1 outEn", enA, 0);

    // Sweep every input word: order of the bits and zero fill
    for (int v = 0; v < 256; v++) begin
      dinA = v[7:0];
      selectDev();
      check(enA == 1'b1, "R10 enable on select", enA, 1);
      readBits(16, 32'h0, 1'b0, w);
      check(w[15:8] == v[7:0], "R2 R3 R4 frame order", w[15:8], v);
      check(w[7:0] == 8'h00, "R7 zero fill", w[7:0], 0);
      deselectDev();
      check(enA == 1'b0, "R10 release on deselect", enA, 0);
    end

    // Bits taken in from the serial input come out in the order fed
    for (int p = 0; p < 4; p++) begin
      dinA = 8'hFF;
      selectDev();
      readBits(24, {8'h00, pat[p], 16'h0000}, 1'b0, w);
      check(w[23:16] == 8'hFF, "R3 loaded word", w[23:16], 8'hFF);
      check(w[15:8] == pat[p], "R5 serial passthrough", w[15:8], pat[p]);
      check(w[7:0] == 8'h00, "R7 trailing zeros", w[7:0], 0);
      deselectDev();
    end

    // Deselected: clock edges do not move the register
    dinA = 8'h00;
    selectDev();
    readBits(8, 32'h55, 1'b0, w);
    deselectDev();
    held = outA;
    check(held == 1'b0, "R5 register holds 01010101", held, 0);
    sdi = 1'b1;
    for (int k = 0; k < 8; k++) begin
      pulse();
      check(outA == held, "R6 no shift while deselected", outA, held);
      check(enA == 1'b0, "R6 output released", enA, 0);
    end
    sdi = 1'b0;

    // Change on din in mid-frame is ignored until the next select
    dinA = 8'hC3;
    selectDev();
    readBits(3, 32'h0, 1'b0, w);
    dinA = 8'h3C;
    readBits(13, 32'h0, 1'b0, w2);
    check({w[2:0], w2[12:0]} == 16'hC300, "R8 no mid-frame reload",
          {w[2:0], w2[12:0]}, 16'hC300);
    deselectDev();
    selectDev();
    readBits(8, 32'h0, 1'b0, w);
    check(w[7:0] == 8'h3C, "R8 reload on next select", w[7:0], 8'h3C);
    deselectDev();

    // Two blocks in a chain
    for (int c = 0; c < 4; c++) begin
      dinA = chA[c];
      dinB = chB[c];
      selectDev();
      check(enB == 1'b1, "R10 second block enabled", enB, 1);
      readBits(16, 32'h0, 1'b1, w);
      check(w[15:0] == {chB[c], chA[c]}, "R9 chained order", w[15:0], {chB[c], chA[c]});
      deselectDev();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule